// File: doc/BRIEF.md
# Multi-Channel Link Packet Framer

This block carries four coherence-message channels (request, response, snoop and data) over one link stream of fixed 128-bit beats. The transmit half takes a payload from each channel on a valid/ready handshake. A per-channel permit input gates each channel and stands in for flow control. The transmit half picks one channel by round robin and sends that channel's packet as one beat, or as five beats for the data channel. Beat 0 of every packet carries a 2-bit channel tag in its top bits.

The receive half takes beats from a link beat input. It reads the tag to learn how many beats belong to the packet, and rebuilds the payload. It presents the payload on the output of the matching channel once the last beat is in. A link partner has one instance of the block at each end: the transmit half of one instance feeds the receive half of the other.

Top module: `link_chan_framer`

## Requirements
- R1: After reset, no channel output valid and no transmit beat valid is asserted, and the receive beat input is ready.
- R2: `tx_valid` is high exactly when a data packet is part-way through transmission, or when at least one channel has both its valid and its permit bit high (permit bit 0 = request, 1 = response, 2 = snoop, 3 = data).
- R3: When no packet is in progress, the granted channel is the first one that is both valid and permitted, searching upward in the order request, response, snoop, data and wrapping around. The search starts at the channel after the one whose packet completed last, and starts at request after reset.
- R4: Bits [127:126] of the first beat hold the channel tag: 00 request, 01 response, 10 snoop, 11 data.
- R5: A request (109-bit), response (45-bit) or snoop (105-bit) packet is a single beat. The payload sits in bits [W-1:0], and the bits from W up to 125 are zero.
- R6: A data packet (623-bit payload) is five beats. Beat 0 bits [125:0] hold payload bits [125:0]. Beats 1 to 4 form a 512-bit field whose bit i holds payload bit 126+i, and field bits from 497 upward are zero.
- R7: Once the first data beat has been accepted, the next four accepted beats are the rest of that data packet, whatever the permits and the other valids do.
- R8: A channel's input ready pulses only in the cycle in which the last beat of that channel's packet is accepted on the link.
- R9: The receive half raises the valid of the channel named by the tag in the cycle after the last beat of a packet is accepted, and at no other time. At most one channel output valid is high at once.
- R10: While a rebuilt payload waits on a channel whose ready is low, `rx_ready` is low and the payload stays unchanged. In a cycle where that ready is high, `rx_ready` is high.
- R11: When transmit is looped back to receive, each channel's payloads come out intact and in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| permit | input | 4 | Per-channel transmit permission |
| req_valid | input | 1 | Request payload valid |
| req_ready | output | 1 | Request payload taken |
| req_data | input | 109 | Request payload |
| rsp_valid | input | 1 | Response payload valid |
| rsp_ready | output | 1 | Response payload taken |
| rsp_data | input | 45 | Response payload |
| snp_valid | input | 1 | Snoop payload valid |
| snp_ready | output | 1 | Snoop payload taken |
| snp_data | input | 105 | Snoop payload |
| dat_valid | input | 1 | Data payload valid |
| dat_ready | output | 1 | Data payload taken |
| dat_data | input | 623 | Data payload |
| tx_valid | output | 1 | Link beat out valid |
| tx_ready | input | 1 | Link beat out accepted |
| tx_beat | output | 128 | Link beat out |
| rx_valid | input | 1 | Link beat in valid |
| rx_ready | output | 1 | Link beat in accepted |
| rx_beat | input | 128 | Link beat in |
| oreq_valid | output | 1 | Rebuilt request valid |
| oreq_ready | input | 1 | Rebuilt request taken |
| oreq_data | output | 109 | Rebuilt request |
| orsp_valid | output | 1 | Rebuilt response valid |
| orsp_ready | input | 1 | Rebuilt response taken |
| orsp_data | output | 45 | Rebuilt response |
| osnp_valid | output | 1 | Rebuilt snoop valid |
| osnp_ready | input | 1 | Rebuilt snoop taken |
| osnp_data | output | 105 | Rebuilt snoop |
| odat_valid | output | 1 | Rebuilt data valid |
| odat_ready | input | 1 | Rebuilt data taken |
| odat_data | output | 623 | Rebuilt data |

## Verification
A wrong round-robin pointer shows up at once: the tag of the next packet differs from the channel the model expects, in the same cycle that packet's first beat is offered. A wrong transmit beat index puts the wrong slice of the data payload on `tx_beat`, or ends the lock early so another tag appears mid-packet. Either is caught on that beat. On the receive side, a bad beat counter or pending flag raises the wrong channel's valid, or raises it in the wrong cycle, one cycle after the faulty beat. A corrupted rebuild buffer shows up as a payload mismatch when that payload is handed off.

// File: rtl/link_chan_framer.sv
module link_chan_framer #(
  parameter int BEAT_W    = 128,
  parameter int REQ_W     = 109,
  parameter int RSP_W     = 45,
  parameter int SNP_W     = 105,
  parameter int DAT_W     = 623,
  parameter int DAT_BEATS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        permit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [REQ_W-1:0]  req_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [RSP_W-1:0]  rsp_data,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic [SNP_W-1:0]  snp_data,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [DAT_W-1:0]  dat_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BEAT_W-1:0] tx_beat,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BEAT_W-1:0] rx_beat,
  output logic              oreq_valid,
  input  logic              oreq_ready,
  output logic [REQ_W-1:0]  oreq_data,
  output logic              orsp_valid,
  input  logic              orsp_ready,
  output logic [RSP_W-1:0]  orsp_data,
  output logic              osnp_valid,
  input  logic              osnp_ready,
  output logic [SNP_W-1:0]  osnp_data,
  output logic              odat_valid,
  input  logic              odat_ready,
  output logic [DAT_W-1:0]  odat_data
);
  localparam int TAG_W   = 2;
  localparam int PAY0_W  = BEAT_W - TAG_W;
  localparam int FRAME_W = BEAT_W * DAT_BEATS;
  localparam int DPAD    = FRAME_W - DAT_W - TAG_W;
  localparam int IDX_W   = $clog2(DAT_BEATS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DAT_BEATS - 1);
  localparam logic [1:0] T_REQ = 2'd0, T_RSP = 2'd1, T_SNP = 2'd2, T_DAT = 2'd3;

  // ---------------- transmit ----------------
  logic [3:0]       elig;
  logic [1:0]       rr, gnt, ci;
  logic             found, tlock, tfire, tlast;
  logic [IDX_W-1:0] tidx;
  logic [FRAME_W-1:0] dframe;

  assign elig = {dat_valid, snp_valid, rsp_valid, req_valid} & permit;

  always_comb begin
    gnt   = rr;
    found = 1'b0;
    for (int k = 0; k < 4; k++) begin
      ci = rr + 2'(k);
      if (!found && elig[ci]) begin
        gnt   = ci;
        found = 1'b1;
      end
    end
    if (tlock) gnt = T_DAT;
  end

  assign dframe   = {{DPAD{1'b0}}, dat_data[DAT_W-1:PAY0_W], T_DAT, dat_data[PAY0_W-1:0]};
  assign tx_valid = tlock | found;
  assign tfire    = tx_valid & tx_ready;
  assign tlast    = (gnt != T_DAT) || (tidx == LAST_IDX);

  always_comb begin
    case (gnt)
      T_REQ:   tx_beat = {T_REQ, {(PAY0_W-REQ_W){1'b0}}, req_data};
      T_RSP:   tx_beat = {T_RSP, {(PAY0_W-RSP_W){1'b0}}, rsp_data};
      T_SNP:   tx_beat = {T_SNP, {(PAY0_W-SNP_W){1'b0}}, snp_data};
      default: tx_beat = dframe[int'(tidx)*BEAT_W +: BEAT_W];
    endcase
  end

  assign req_ready = tfire && gnt == T_REQ;
  assign rsp_ready = tfire && gnt == T_RSP;
  assign snp_ready = tfire && gnt == T_SNP;
  assign dat_ready = tfire && gnt == T_DAT && tidx == LAST_IDX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr    <= T_REQ;
      tlock <= 1'b0;
      tidx  <= '0;
    end else if (tfire) begin
      if (tlast) begin
        tlock <= 1'b0;
        tidx  <= '0;
        rr    <= 2'(gnt + 2'd1);
      end else begin
        tlock <= 1'b1;
        tidx  <= tidx + IDX_W'(1);
      end
    end
  end

  // ---------------- receive ----------------
  logic [FRAME_W-1:0] rbuf;
  logic [IDX_W-1:0]   ridx;
  logic               pend, sel_ready, rfire, rlast;
  logic [1:0]         rtag, cur_tag;

  assign rtag = rbuf[BEAT_W-1 -: TAG_W];

  always_comb begin
    case (rtag)
      T_REQ:   sel_ready = oreq_ready;
      T_RSP:   sel_ready = orsp_ready;
      T_SNP:   sel_ready = osnp_ready;
      default: sel_ready = odat_ready;
    endcase
  end

  assign rx_ready = !pend || sel_ready;
  assign rfire    = rx_valid && rx_ready;
  assign cur_tag  = (ridx == '0) ? rx_beat[BEAT_W-1 -: TAG_W] : rtag;
  assign rlast    = (cur_tag != T_DAT) || (ridx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ridx <= '0;
      rbuf <= '0;
    end else begin
      if (pend && sel_ready) pend <= 1'b0;
      if (rfire) begin
        rbuf[int'(ridx)*BEAT_W +: BEAT_W] <= rx_beat;
        if (rlast) begin
          pend <= 1'b1;
          ridx <= '0;
        end else begin
          ridx <= ridx + IDX_W'(1);
        end
      end
    end
  end

  assign oreq_valid = pend && rtag == T_REQ;
  assign orsp_valid = pend && rtag == T_RSP;
  assign osnp_valid = pend && rtag == T_SNP;
  assign odat_valid = pend && rtag == T_DAT;
  assign oreq_data  = rbuf[REQ_W-1:0];
  assign orsp_data  = rbuf[RSP_W-1:0];
  assign osnp_data  = rbuf[SNP_W-1:0];
  assign odat_data  = {rbuf[DAT_W+TAG_W-1:BEAT_W], rbuf[PAY0_W-1:0]};

  // ---------------- assertions ----------------
  p_nointerleave_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tidx != '0) |-> (tx_valid && !req_ready && !rsp_ready && !snp_ready));
  p_dat_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> (tx_valid && tx_ready && tx_beat[BEAT_W-1 -: TAG_W] != T_DAT));
  p_onehot_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({oreq_valid, orsp_valid, osnp_valid, odat_valid}));
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (oreq_valid && !oreq_ready) |=> (oreq_valid && $stable(oreq_data)));
  p_hold_dat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (odat_valid && !odat_ready) |=> (odat_valid && $stable(odat_data)));
  p_block_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((osnp_valid && !osnp_ready) || (orsp_valid && !orsp_ready)) |-> !rx_ready);
endmodule

// File: tb/tb_link_chan_framer.sv
module tb_link_chan_framer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [3:0] permit;
  logic req_valid, rsp_valid, snp_valid, dat_valid;
  logic req_ready, rsp_ready, snp_ready, dat_ready;
  logic [108:0] req_data;
  logic [44:0]  rsp_data;
  logic [104:0] snp_data;
  logic [622:0] dat_data;
  logic tx_valid, rx_ready;
  logic [127:0] tx_beat;
  logic oreq_valid, orsp_valid, osnp_valid, odat_valid;
  logic oreq_ready, orsp_ready, osnp_ready, odat_ready;
  logic [108:0] oreq_data;
  logic [44:0]  orsp_data;
  logic [104:0] osnp_data;
  logic [622:0] odat_data;

  link_chan_framer dut (
    .clk(clk), .rst_n(rst_n), .permit(permit),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_data(snp_data),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
    .tx_valid(tx_valid), .tx_ready(rx_ready), .tx_beat(tx_beat),
    .rx_valid(tx_valid), .rx_ready(rx_ready), .rx_beat(tx_beat),
    .oreq_valid(oreq_valid), .oreq_ready(oreq_ready), .oreq_data(oreq_data),
    .orsp_valid(orsp_valid), .orsp_ready(orsp_ready), .orsp_data(orsp_data),
    .osnp_valid(osnp_valid), .osnp_ready(osnp_ready), .osnp_data(osnp_data),
    .odat_valid(odat_valid), .odat_ready(odat_ready), .odat_data(odat_data));

  int checks = 0, failures = 0, cyc = 0;
  logic [639:0] srcq[4][$];
  logic [639:0] expq[4][$];
  int widths[4] = '{109, 45, 105, 623};
  logic [3:0] vf = '0;
  int rr_m = 0, bidx_m = 0, pend_m = -1;
  bit lock_m = 0;

  task automatic chk(input bit ok, input string req, input logic [639:0] act, input logic [639:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [639:0] rnd_payload(input int w);
    logic [639:0] v;
    for (int i = 0; i < 20; i++) v[i*32 +: 32] = $urandom;
    for (int i = 0; i < 640; i++) if (i >= w) v[i] = 1'b0;
    return v;
  endfunction

  function automatic logic [127:0] dat_beat(input logic [639:0] p, input int k);
    logic [127:0] b;
    for (int j = 0; j < 128; j++) begin
      int pos;
      pos = k * 128 + j;
      if (pos == 126 || pos == 127) b[j] = 1'b1;
      else if (pos < 126) b[j] = p[pos];
      else b[j] = (pos - 2 < 623) ? p[pos - 2] : 1'b0;
    end
    return b;
  endfunction

  function automatic logic [639:0] out_data(input int c);
    case (c)
      0: return 640'(oreq_data);
      1: return 640'(orsp_data);
      2: return 640'(osnp_data);
      default: return 640'(odat_data);
    endcase
  endfunction

  initial begin
    int cap = 40000;
    rst_n = 1'b0; permit = '0; vf = '0;
    {req_valid, rsp_valid, snp_valid, dat_valid} = '0;
    req_data = '0; rsp_data = '0; snp_data = '0; dat_data = '0;
    {oreq_ready, orsp_ready, osnp_ready, odat_ready} = '0;
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < (c == 3 ? 50 : 80); n++) srcq[c].push_back(rnd_payload(widths[c]));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(tx_valid == 1'b0, "R1 tx_valid", 640'(tx_valid), 0);
    chk({oreq_valid, orsp_valid, osnp_valid, odat_valid} == 4'b0, "R1 out valids",
        640'({oreq_valid, orsp_valid, osnp_valid, odat_valid}), 0);
    chk(rx_ready == 1'b1, "R1 rx_ready", 640'(rx_ready), 1);

    while (cyc < cap) begin
      logic [3:0] elig, oready, ov, exp_rdy, act_rdy;
      int g;
      bit fire, last;
      @(negedge clk);
      cyc++;
      for (int c = 0; c < 4; c++)
        if (!vf[c] && srcq[c].size() > 0 && ($urandom % 10) < 7) vf[c] = 1'b1;
      if (cyc >= 300 && cyc < 360) permit = 4'b0000;
      else if (cyc >= 600 && cyc < 700) permit = 4'b1000;
      else permit = 4'($urandom) | 4'($urandom);
      if (cyc >= 400 && cyc < 440) oready = 4'b0000;
      else oready = 4'($urandom) | 4'($urandom) | 4'($urandom);
      {dat_valid, snp_valid, rsp_valid, req_valid} = vf;
      req_data = srcq[0].size() > 0 ? srcq[0][0][108:0] : '0;
      rsp_data = srcq[1].size() > 0 ? srcq[1][0][44:0]  : '0;
      snp_data = srcq[2].size() > 0 ? srcq[2][0][104:0] : '0;
      dat_data = srcq[3].size() > 0 ? srcq[3][0][622:0] : '0;
      {odat_ready, osnp_ready, orsp_ready, oready[0]} = oready;
      oreq_ready = oready[0];
      #1;
      // receive-side outputs from model state
      ov = {odat_valid, osnp_valid, orsp_valid, oreq_valid};
      chk(ov == ((pend_m >= 0) ? 4'(1 << pend_m) : 4'b0), "R9 out valid", 640'(ov),
          640'((pend_m >= 0) ? (1 << pend_m) : 0));
      chk(rx_ready == ((pend_m < 0) || oready[pend_m < 0 ? 0 : pend_m]), "R10 rx_ready",
          640'(rx_ready), 640'((pend_m < 0) || oready[pend_m < 0 ? 0 : pend_m]));
      // transmit side
      elig = vf & permit;
      g = -1;
      if (lock_m) g = 3;
      else for (int k = 0; k < 4; k++) if (g < 0 && elig[(rr_m + k) % 4]) g = (rr_m + k) % 4;
      chk(tx_valid == (g >= 0), "R2 tx_valid", 640'(tx_valid), 640'(g >= 0));
      if (g >= 0 && tx_valid) begin
        logic [127:0] eb;
        if (g == 3) eb = dat_beat(srcq[3][0], bidx_m);
        else begin
          eb = srcq[g][0][127:0];
          eb[127:126] = 2'(g);
        end
        if (bidx_m == 0)
          chk(tx_beat[127:126] == 2'(g), "R3 R4 grant tag", 640'(tx_beat[127:126]), 640'(g));
        chk(tx_beat == eb, g == 3 ? (lock_m ? "R7 R6 data beat" : "R6 data beat") : "R5 single beat",
            640'(tx_beat), 640'(eb));
      end
      fire = tx_valid && rx_ready;
      last = fire && g >= 0 && (g != 3 || bidx_m == 4);
      exp_rdy = last ? 4'(1 << g) : 4'b0;
      act_rdy = {dat_ready, snp_ready, rsp_ready, req_ready};
      chk(act_rdy == exp_rdy, "R8 input ready", 640'(act_rdy), 640'(exp_rdy));
      // sink handshake
      if (pend_m >= 0 && oready[pend_m]) begin
        logic [639:0] e;
        e = expq[pend_m].pop_front();
        chk(out_data(pend_m) == e, "R11 payload", out_data(pend_m), e);
        pend_m = -1;
      end
      // model updates for the coming edge
      if (fire && g >= 0) begin
        if (last) begin
          expq[g].push_back(srcq[g].pop_front());
          vf[g] = 1'b0;
          lock_m = 0; bidx_m = 0; rr_m = (g + 1) % 4;
          pend_m = g;
        end else begin
          lock_m = 1; bidx_m++;
        end
      end
      if (cyc > 800 && srcq[0].size() == 0 && srcq[1].size() == 0 && srcq[2].size() == 0 &&
          srcq[3].size() == 0 && pend_m < 0 && !lock_m) break;
    end
    chk(cyc < cap, "R11 watchdog", 640'(cyc), 640'(cap));
    for (int c = 0; c < 4; c++)
      chk(expq[c].size() == 0 && srcq[c].size() == 0, "R11 all delivered",
          640'(expq[c].size() + srcq[c].size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule